// File: doc/BRIEF.md
# Staggered Four-Lane Jitter Pattern Generator

This block produces a repeating test frame for a four-lane, byte-wide link. Each cycle it presents one column of four bytes, with lane 3 in the top byte and lane 0 in the bottom byte. The columns go to a separate per-lane 8B/10B encoder. A frame opens with a disparity-control column and carries one or two copies of a run-length core sequence. A fixed check column closes the frame, and an idle gap of a set number of rows follows. The lanes are de-phased on purpose. Lanes 3 and 1 run long stretches of the low-transition byte 0x7E first and the high-density bytes later. Lanes 2 and 0 run the same material in the opposite order.

A mode input picks one of two frame variants. The long variant carries the core twice behind control column 55 00 07 07 and ends with check column DD 09 AE 5B. The short variant carries the core once behind 55 55 07 07 and ends with CC 08 09 CA. The short variant depends on an odd gap row count, so that each lane's running disparity alternates from one frame to the next. A downstream ready input holds the whole sequence in place.

Top module: `jitpat_gen`

## Requirements
- R1: After reset the first column presented is the control column with the start-of-frame flag set.
- R2: Output bits 31:24 carry lane 3, bits 23:16 lane 2, bits 15:8 lane 1 and bits 7:0 lane 0. The first core column reads 0x7E on lane 3 and 0xB5 on lane 0.
- R3: The core is 188 columns, in this order: 40 × 7EB57EB5; 8 alternating columns 7EEB7EEB / 7EF47EF4, starting with EB; 84 × 7E7E7E7E; 7 alternating columns F47EF47E / EB7EEB7E, starting with F4; 1 × AB7EAB7E; 40 × B57EB57E; 7 alternating columns EBF4EBF4 / F4EBF4EB, starting with EBF4; 1 × F4ABF4AB.
- R4: Mode input 1 gives the long frame: 0x550007 07, then the core twice, then 0xDD09AE5B, for 378 columns in total.
- R5: Mode input 0 gives the short frame: 0x55550707, then the core once, then 0xCC0809CA, for 190 columns in total.
- R6: The start flag is high only on the control column and the end flag only on the check column. The start, end and idle flags are never high together.
- R7: Straight after the check column comes a gap of GAP_ROWS columns (default 3, an odd number). During the gap the idle flag is high and every byte equals IDLE_BYTE (default 0x07). The next control column follows the gap.
- R8: While ready is low the sequence does not advance. The flags and the column stay unchanged, except that the control column follows the mode input.
- R9: The mode is captured on the cycle the control column is accepted. A mode change at any other time has no effect until the next control column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ready_i | input | 1 | Downstream accepts the present column |
| long_mode_i | input | 1 | 1 selects the long frame, 0 the short frame |
| col_o | output | 32 | Column, lane 3 in bits 31:24 down to lane 0 in bits 7:0 |
| sof_o | output | 1 | Present column is the control column |
| eof_o | output | 1 | Present column is the check column |
| idle_o | output | 1 | Present column is a gap row |

## Verification
Two functions can fall in the same cycle. A ready stall can land on the cycle where the run counter reloads and the entry index steps, or where a core pass wraps into the check column or the second pass. A mode change can also land on the cycle the control column is held or accepted. The bench provokes both by combining dense pseudo-periodic stalls with mode toggles whose period is coprime to the frame length, so the two eventually line up on every boundary. Each column is compared against an arithmetic model of the frame. The model latches the mode only when it sees the control column accepted. Frame and gap lengths are measured from the flags alone.

// File: rtl/jp_pkg.sv
package jp_pkg;
  localparam int LANES     = 4;
  localparam int BYTE_W    = 8;
  localparam int COL_W     = LANES * BYTE_W;
  localparam int N_ENTRY   = 27;
  localparam int IDX_W     = $clog2(N_ENTRY);
  localparam int CNT_W     = 7;
  localparam int CORE_COLS = 188;

  typedef logic [COL_W-1:0] col_t;

  typedef struct packed {
    col_t             col;
    logic [CNT_W-1:0] cnt;
  } run_t;

  typedef enum logic [1:0] {ST_CTRL, ST_CORE, ST_CHECK, ST_GAP} phase_e;

  localparam col_t CTRL_LONG  = 32'h5500_0707;
  localparam col_t CTRL_SHORT = 32'h5555_0707;
  localparam col_t CHK_LONG   = 32'hDD09_AE5B;
  localparam col_t CHK_SHORT  = 32'hCC08_09CA;

  // Run-length entry: column and repeat count, derived from the entry index.
  function automatic run_t run_entry(input logic [IDX_W-1:0] idx);
    run_t r;
    int   i;
    i = int'(idx);
    r.cnt = CNT_W'(1);
    if (i == 0) begin
      r.col = 32'h7EB5_7EB5; r.cnt = CNT_W'(40);
    end else if (i <= 8) begin
      r.col = idx[0] ? 32'h7EEB_7EEB : 32'h7EF4_7EF4;
    end else if (i == 9) begin
      r.col = 32'h7E7E_7E7E; r.cnt = CNT_W'(84);
    end else if (i <= 16) begin
      r.col = idx[0] ? 32'hEB7E_EB7E : 32'hF47E_F47E;
    end else if (i == 17) begin
      r.col = 32'hAB7E_AB7E;
    end else if (i == 18) begin
      r.col = 32'hB57E_B57E; r.cnt = CNT_W'(40);
    end else if (i <= 25) begin
      r.col = idx[0] ? 32'hEBF4_EBF4 : 32'hF4EB_F4EB;
    end else begin
      r.col = 32'hF4AB_F4AB;
    end
    return r;
  endfunction

  // Whole-frame column count for one mode.
  function automatic int frame_len(input logic long_mode);
    return 2 + CORE_COLS * (long_mode ? 2 : 1);
  endfunction
endpackage

// File: rtl/jp_run_walker.sv
module jp_run_walker
  import jp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output col_t col_o,
  output logic wrap_o
);
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] rem_q;
  run_t             cur_run, nxt_run;
  logic             entry_done, last_entry;
  logic [IDX_W-1:0] idx_nx;

  assign cur_run    = run_entry(idx_q);
  assign entry_done = (rem_q == CNT_W'(1));
  assign last_entry = (idx_q == IDX_W'(N_ENTRY - 1));
  assign idx_nx     = last_entry ? '0 : idx_q + 1'b1;
  assign nxt_run    = run_entry(idx_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rem_q <= CNT_W'(40);
    end else if (step_i) begin
      if (entry_done) begin
        idx_q <= idx_nx;
        rem_q <= nxt_run.cnt;
      end else begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign col_o  = cur_run.col;
  assign wrap_o = entry_done && last_entry;

  // R3: the repeat counter never leaves 1..count of the current entry
  a_r3_rem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != '0) && (rem_q <= cur_run.cnt));
  // R3: a wrap brings the walker back to the first core column
  a_r3_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && wrap_o |=> col_o == 32'h7EB5_7EB5);
  // R8: without a step the walker's column is held
  a_r8_walker_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(col_o));
endmodule

// File: rtl/jp_gap_timer.sv
module jp_gap_timer #(
  parameter int ROWS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (ROWS < 2) ? 1 : $clog2(ROWS);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (run_i) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  // R7: the row counter stays within the configured gap
  a_r7_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < ROWS);
endmodule

// File: rtl/jitpat_gen.sv
module jitpat_gen
  import jp_pkg::*;
#(
  parameter int          GAP_ROWS  = 3,
  parameter logic [7:0]  IDLE_BYTE = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ready_i,
  input  logic        long_mode_i,
  output logic [31:0] col_o,
  output logic        sof_o,
  output logic        eof_o,
  output logic        idle_o
);
  localparam int FL_W = $clog2(frame_len(1'b1) + 1);

  phase_e phase_q;
  logic   pass_q;
  logic   long_q;
  logic   eff_long;
  col_t   walk_col;
  logic   walk_wrap;
  logic   walk_step;
  logic   core_end;
  logic   gap_run, gap_done;

  assign walk_step = ready_i && (phase_q == ST_CORE);
  assign core_end  = walk_wrap && (!long_q || pass_q);
  assign gap_run   = ready_i && (phase_q == ST_GAP);
  assign eff_long  = (phase_q == ST_CTRL) ? long_mode_i : long_q;

  jp_run_walker i_walker (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (walk_step),
    .col_o  (walk_col),
    .wrap_o (walk_wrap)
  );

  jp_gap_timer #(.ROWS(GAP_ROWS)) i_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (gap_run),
    .done_o (gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_CTRL;
      pass_q  <= 1'b0;
      long_q  <= 1'b1;
    end else if (ready_i) begin
      unique case (phase_q)
        ST_CTRL: begin
          phase_q <= ST_CORE;
          long_q  <= long_mode_i;
          pass_q  <= 1'b0;
        end
        ST_CORE: begin
          if (core_end)       phase_q <= ST_CHECK;
          else if (walk_wrap) pass_q  <= 1'b1;
        end
        ST_CHECK: phase_q <= ST_GAP;
        ST_GAP:   if (gap_done) phase_q <= ST_CTRL;
        default:  phase_q <= ST_CTRL;
      endcase
    end
  end

  always_comb begin
    col_o  = walk_col;
    sof_o  = 1'b0;
    eof_o  = 1'b0;
    idle_o = 1'b0;
    unique case (phase_q)
      ST_CTRL: begin
        col_o = eff_long ? CTRL_LONG : CTRL_SHORT;
        sof_o = 1'b1;
      end
      ST_CHECK: begin
        col_o = long_q ? CHK_LONG : CHK_SHORT;
        eof_o = 1'b1;
      end
      ST_GAP: begin
        col_o  = {LANES{IDLE_BYTE}};
        idle_o = 1'b1;
      end
      default: col_o = walk_col;
    endcase
  end

  // Accepted-column count since the control column, for the length check.
  logic [FL_W-1:0] frm_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   frm_cnt_q <= '0;
    else if (ready_i && sof_o)    frm_cnt_q <= FL_W'(1);
    else if (walk_step)           frm_cnt_q <= frm_cnt_q + 1'b1;
  end

  // R6: at most one frame marker per column
  a_r6_marks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_o, eof_o, idle_o}));
  // R4: the check column arrives after exactly the frame's column count
  a_r4_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> int'(frm_cnt_q) == frame_len(long_q) - 1);
  // R7: the gap begins right after an accepted check column
  a_r7_gap_follows_check: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o && ready_i |=> idle_o);
  // R7: the last accepted gap row hands over to a control column
  a_r7_gap_to_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o && ready_i && gap_done |=> sof_o);
  // R8: markers hold while ready is low
  a_r8_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> $stable({sof_o, eof_o, idle_o}));
  // R8: data holds while ready is low outside the control column
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i && !sof_o |=> $stable(col_o));
  // R9: the captured mode only changes at the control column
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != ST_CTRL |=> $stable(long_q));
endmodule

// File: tb/test_jitpat_gen.sv
`timescale 1ns/1ps
module test_jitpat_gen;
  localparam int GAP  = 3;
  localparam int CORE = 188;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ready = 1'b0;
  logic        long_mode = 1'b1;
  logic [31:0] col;
  logic        sof, eof, idle;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  jitpat_gen #(.GAP_ROWS(GAP), .IDLE_BYTE(8'h07)) i_jitpat_gen (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .long_mode_i(long_mode),
    .col_o(col), .sof_o(sof), .eof_o(eof), .idle_o(idle)
  );

  function automatic logic [31:0] core_col(input int p);
    int k;
    if (p < 40) return 32'h7EB57EB5;
    if (p < 48) begin k = p - 40; return (k % 2 == 0) ? 32'h7EEB7EEB : 32'h7EF47EF4; end
    if (p < 132) return 32'h7E7E7E7E;
    if (p < 139) begin k = p - 132; return (k % 2 == 0) ? 32'hF47EF47E : 32'hEB7EEB7E; end
    if (p == 139) return 32'hAB7EAB7E;
    if (p < 180) return 32'hB57EB57E;
    if (p < 187) begin k = p - 180; return (k % 2 == 0) ? 32'hEBF4EBF4 : 32'hF4EBF4EB; end
    return 32'hF4ABF4AB;
  endfunction

  function automatic int flen(input logic lm);
    return lm ? 2 + 2 * CORE : 2 + CORE;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // model state
  int   pos = 0;
  logic m_long = 1'b1;
  int   acc_cnt = 0;
  int   gap_cnt = 0;
  logic p_sof = 0, p_eof = 0, p_idle = 0;
  logic last_ready = 0, last_mode = 1;

  task automatic advance();
    if (last_ready) begin
      // R4 R5: frame length measured from the markers
      if (p_sof) acc_cnt = 1;
      else if (!p_idle) acc_cnt++;
      if (p_eof)
        check(acc_cnt == flen(m_long), m_long ? "R4 frame length" : "R5 frame length",
              32'(acc_cnt), 32'(flen(m_long)));
      // R7: gap length from the idle marker
      if (p_idle) gap_cnt++;
      if (p_sof && gap_cnt != 0) begin
        check(gap_cnt == GAP, "R7 gap length", 32'(gap_cnt), 32'(GAP));
      end
      if (p_sof) gap_cnt = 0;
      if (pos == 0) m_long = last_mode;
      pos++;
      if (pos == flen(m_long) + GAP) pos = 0;
    end
  endtask

  task automatic compare(input bit stalled);
    logic [31:0] e_col;
    logic        e_sof, e_eof, e_idle;
    logic        lm;
    string       tag;
    lm = (pos == 0) ? long_mode : m_long;
    e_sof = (pos == 0);
    e_eof = (pos == flen(lm) - 1);
    e_idle = (pos >= flen(lm));
    if (e_sof) begin e_col = lm ? 32'h55000707 : 32'h55550707; tag = "R9 control column"; end
    else if (e_eof) begin
      e_col = lm ? 32'hDD09AE5B : 32'hCC0809CA;
      tag = lm ? "R4 check column" : "R5 check column";
    end
    else if (e_idle) begin e_col = 32'h07070707; tag = "R7 gap column"; end
    else begin e_col = core_col((pos - 1) % CORE); tag = "R3 core column"; end
    if (stalled) tag = {"R8 held ", tag};
    check(col === e_col, tag, col, e_col);
    check({sof, eof, idle} === {e_sof, e_eof, e_idle}, "R6 markers",
          32'({sof, eof, idle}), 32'({e_sof, e_eof, e_idle}));
    if (pos == 1) begin
      check(col[31:24] === 8'h7E, "R2 lane 3 byte", 32'(col[31:24]), 32'h7E);
      check(col[7:0] === 8'hB5, "R2 lane 0 byte", 32'(col[7:0]), 32'hB5);
    end
    p_sof = sof; p_eof = eof; p_idle = idle;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(sof === 1'b1 && col === 32'h55000707, "R1 reset column", col, 32'h55000707);
    for (int cyc = 0; cyc < 9000; cyc++) begin
      @(negedge clk);
      advance();
      compare(!last_ready);
      if (cyc < 2000) begin
        ready = 1'b1; long_mode = 1'b1;
      end else if (cyc < 4000) begin
        ready = 1'b1; long_mode = ((cyc / 150) % 2 == 0);
      end else if (cyc < 8000) begin
        ready = ((cyc * 7) % 11) >= 3; long_mode = ((cyc / 97) % 2 == 1);
      end else begin
        ready = ((cyc / 5) % 3) != 0; long_mode = 1'b0;
      end
      last_ready = ready;
      last_mode  = long_mode;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule